// File: doc/BRIEF.md
# Conditional-Poll DMA Descriptor Engine

This block is one DMA channel sequencer. It walks two linked lists of four-word descriptors held in memory, using a single-beat master port that has one request channel and one response channel. It runs the gather list (peripheral to internal byte buffer) to its end first. It then runs the scatter list (internal buffer back out to memory). A data descriptor moves bytes one at a time. A conditional descriptor placed in front of a data descriptor makes that transfer wait on a peripheral status word. The engine reads the status word, masks it, and moves a fixed chunk of bytes only when a masked bit is set. Between unsuccessful reads it waits for a programmable interval, and it polls again after every chunk until the data descriptor's total is reached.

Software builds the lists, sets the two head pointers and pulses `start`. The engine then writes a completion word back into each data descriptor it finishes. When the scatter list ends, it raises an interrupt pulse if interrupts are enabled.

Master port rules. The request channel uses valid/ready. Once `bus_req_valid` is high, the request fields stay constant until a cycle where `bus_req_ready` is high. Every accepted request, read or write, gets exactly one response cycle (`bus_rsp_valid` high). At most one request is outstanding, and the engine cannot stall the response channel.

Top module: `cpdma_engine`

## Requirements
- R1: After reset `busy`, `irq` and `bus_req_valid` are 0.
- R2: A descriptor is fetched as four word reads at the pointer with bit 0 cleared, at offsets +0, +4, +8 and +12 and in that order: link, target address, control, fourth word. A link of zero ends a list.
- R3: A data descriptor has control bit 0 = enable and control bits 31:16 = byte count. It moves that many bytes as single-byte accesses (`bus_req_byte`=1, data in bits 7:0). The address rises by one per byte unless control bit 4 (hold address) is set.
- R4: After the gather list ends, the scatter list writes the buffered bytes in arrival order to its own data descriptors' targets.
- R5: When a data descriptor finishes, the engine writes the word {byte count in bits 31:16, bit 0 = 1, other bits 0} to descriptor address +12.
- R6: A link with bit 0 set points to a conditional descriptor. Its fourth word is a mask, its target is a status address, and control bits 31:16 are the chunk size. No data byte of the following data descriptor moves until a read of the status AND the mask is nonzero.
- R7: Control bits 15:4 of a conditional descriptor hold the interval N. With a bus that accepts at once and answers in the next cycle, a failed status read is followed by the next status read N+4 cycles later.
- R8: After each hit, the engine moves min(chunk, bytes left) bytes and then polls again, until the data descriptor's total is moved.
- R9: A descriptor with enable = 0 makes no data access and gets no write-back. The engine follows its link.
- R10: When the scatter list ends, `busy` falls. In that same cycle `irq` is high for exactly one cycle if `irq_enable` was 1, and stays low otherwise.
- R11: A request that is not yet accepted keeps its fields stable, and no new request appears while a response is owed.
- R12: The buffer holds FIFO_DEPTH bytes. While it is full, no gather byte read is issued and the engine stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run when idle |
| gather_head | input | ADDR_W | First link of the gather list |
| scatter_head | input | ADDR_W | First link of the scatter list |
| irq_enable | input | 1 | Allows the end-of-run interrupt |
| busy | output | 1 | Run in progress |
| irq | output | 1 | One-cycle end-of-run pulse |
| bus_req_valid | output | 1 | Request present |
| bus_req_ready | input | 1 | Request accepted this cycle |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_byte | output | 1 | 1 = single byte, 0 = word |
| bus_req_addr | output | ADDR_W | Request address |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response for the outstanding request |
| bus_rsp_rdata | input | 32 | Read data |

## Verification
On every cycle, the embedded properties check the request-channel rules: held fields while stalled, and no overlap with an owed response. They also check that the buffer never overflows or underflows, that the poll timer steps down by one, and that the interrupt is a single pulse seen only after `busy` drops. Some behaviour only shows in the directed scenarios: the fetch order, address stepping and the hold-address mode, the byte order across the two lists, and the write-back values. The same holds for poll gating by the mask, the exact spacing between polls, chunking with a short last chunk, skipping disabled descriptors, and the stall on a full buffer.

// File: rtl/cpdma_pkg.sv
package cpdma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_FETCH, S_DISPATCH, S_POLL, S_PWAIT, S_MOVE, S_STATUS, S_FINISH
  } cpdma_state_e;

  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_FIX_BIT = 4;
  localparam int unsigned CTL_IVL_LSB = 4;
  localparam int unsigned CTL_CNT_LSB = 16;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned LAST_WORD   = 3;
endpackage

// File: rtl/cpdma_poll_timer.sv
module cpdma_poll_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R7
endmodule

// File: rtl/cpdma_byte_fifo.sv
module cpdma_byte_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] wdata,
  input  logic       pop,
  output logic [7:0] rdata,
  output logic       full,
  output logic       empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign full  = (level == (PW+1)'(DEPTH));
  assign empty = (level == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R12
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R4
endmodule

// File: rtl/cpdma_engine.sv
module cpdma_engine #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned IVL_W      = 12,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] gather_head,
  input  logic [ADDR_W-1:0] scatter_head,
  input  logic              irq_enable,
  output logic              busy,
  output logic              irq,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic              bus_req_byte,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [31:0]       bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [31:0]       bus_rsp_rdata
);
  import cpdma_pkg::*;

  cpdma_state_e state;
  logic              phase_b2m, wait_rsp;
  logic [ADDR_W-1:0] ptr, scatter_q, d_base, d_link, xaddr;
  logic [1:0]        widx;
  logic [DATA_W-1:0] w_link, w_addr, w_ctrl;
  logic              cond_on, hold_addr;
  logic [ADDR_W-1:0] cond_addr;
  logic [DATA_W-1:0] cond_mask;
  logic [IVL_W-1:0]  cond_ivl;
  logic [CNT_W-1:0]  cond_chunk, d_total, left, chunk_left;

  logic rsp_ok, can_issue, poll_hit, tmr_load, tmr_done;
  logic buf_push, buf_pop, buf_full, buf_empty;
  logic [7:0] buf_out;
  logic [ADDR_W-1:0] desc_at;
  logic [CNT_W-1:0]  w_cnt;
  logic unused_ctl_bits;

  assign rsp_ok    = wait_rsp && bus_rsp_valid;
  assign can_issue = !bus_req_valid && !wait_rsp;
  assign poll_hit  = |(bus_rsp_rdata & cond_mask);
  assign tmr_load  = (state == S_POLL) && rsp_ok && !poll_hit;
  assign buf_push  = (state == S_MOVE) && !phase_b2m && rsp_ok;
  assign buf_pop   = (state == S_MOVE) && phase_b2m && can_issue && !buf_empty;
  assign desc_at   = {ptr[ADDR_W-1:1], 1'b0};
  assign w_cnt     = w_ctrl[CTL_CNT_LSB +: CNT_W];
  assign busy      = (state != S_IDLE);
  assign unused_ctl_bits = ^{w_ctrl[3:1]};

  cpdma_poll_timer #(.W(IVL_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(cond_ivl), .expired(tmr_done));

  cpdma_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(buf_push), .wdata(bus_rsp_rdata[7:0]),
    .pop(buf_pop), .rdata(buf_out), .full(buf_full), .empty(buf_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase_b2m <= 1'b0; wait_rsp <= 1'b0; irq <= 1'b0;
      ptr <= '0; scatter_q <= '0; d_base <= '0; d_link <= '0; xaddr <= '0;
      widx <= '0; w_link <= '0; w_addr <= '0; w_ctrl <= '0;
      cond_on <= 1'b0; hold_addr <= 1'b0; cond_addr <= '0; cond_mask <= '0;
      cond_ivl <= '0; cond_chunk <= '0; d_total <= '0; left <= '0; chunk_left <= '0;
      bus_req_valid <= 1'b0; bus_req_write <= 1'b0; bus_req_byte <= 1'b0;
      bus_req_addr <= '0; bus_req_wdata <= '0;
    end else begin
      irq <= 1'b0;
      if (bus_req_valid && bus_req_ready) begin
        bus_req_valid <= 1'b0;
        wait_rsp      <= 1'b1;
      end
      if (rsp_ok) wait_rsp <= 1'b0;

      unique case (state)
        S_IDLE: if (start) begin
          ptr <= gather_head; scatter_q <= scatter_head;
          phase_b2m <= 1'b0; cond_on <= 1'b0; state <= S_NEXT;
        end
        S_NEXT: begin
          if (ptr[ADDR_W-1:1] == '0) begin
            cond_on <= 1'b0;
            if (!phase_b2m) begin phase_b2m <= 1'b1; ptr <= scatter_q; end
            else state <= S_FINISH;
          end else begin
            widx <= '0; state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (can_issue) begin
            bus_req_valid <= 1'b1; bus_req_write <= 1'b0; bus_req_byte <= 1'b0;
            bus_req_addr  <= desc_at + ADDR_W'({widx, 2'b00});
          end
          if (rsp_ok) begin
            unique case (widx)
              2'd0: w_link <= bus_rsp_rdata;
              2'd1: w_addr <= bus_rsp_rdata;
              2'd2: w_ctrl <= bus_rsp_rdata;
              default: cond_mask <= ptr[0] ? bus_rsp_rdata : cond_mask;
            endcase
            if (widx == 2'(LAST_WORD)) state <= S_DISPATCH;
            else widx <= widx + 1'b1;
          end
        end
        S_DISPATCH: begin
          if (!w_ctrl[CTL_EN_BIT]) begin
            ptr <= w_link[ADDR_W-1:0]; state <= S_NEXT;
          end else if (ptr[0]) begin
            cond_on    <= 1'b1;
            cond_addr  <= w_addr[ADDR_W-1:0];
            cond_ivl   <= w_ctrl[CTL_IVL_LSB +: IVL_W];
            cond_chunk <= (w_cnt == '0) ? CNT_W'(1) : w_cnt;
            ptr <= w_link[ADDR_W-1:0]; state <= S_NEXT;
          end else begin
            d_base <= desc_at; d_link <= w_link[ADDR_W-1:0];
            xaddr <= w_addr[ADDR_W-1:0]; hold_addr <= w_ctrl[CTL_FIX_BIT];
            d_total <= w_cnt; left <= w_cnt; chunk_left <= w_cnt;
            if (w_cnt == '0)  state <= S_STATUS;
            else if (cond_on) state <= S_POLL;
            else              state <= S_MOVE;
          end
        end
        S_POLL: begin
          if (can_issue) begin
            bus_req_valid <= 1'b1; bus_req_write <= 1'b0; bus_req_byte <= 1'b0;
            bus_req_addr  <= cond_addr;
          end
          if (rsp_ok) begin
            if (poll_hit) begin
              chunk_left <= (cond_chunk < left) ? cond_chunk : left;
              state <= S_MOVE;
            end else state <= S_PWAIT;
          end
        end
        S_PWAIT: if (tmr_done) state <= S_POLL;
        S_MOVE: begin
          if (!phase_b2m && can_issue && !buf_full) begin
            bus_req_valid <= 1'b1; bus_req_write <= 1'b0; bus_req_byte <= 1'b1;
            bus_req_addr  <= xaddr;
          end
          if (buf_pop) begin
            bus_req_valid <= 1'b1; bus_req_write <= 1'b1; bus_req_byte <= 1'b1;
            bus_req_addr  <= xaddr; bus_req_wdata <= {24'h0, buf_out};
          end
          if (rsp_ok) begin
            left <= left - 1'b1; chunk_left <= chunk_left - 1'b1;
            if (!hold_addr) xaddr <= xaddr + 1'b1;
            if (left == CNT_W'(1))            state <= S_STATUS;
            else if (chunk_left == CNT_W'(1)) state <= S_POLL;
          end
        end
        S_STATUS: begin
          if (can_issue) begin
            bus_req_valid <= 1'b1; bus_req_write <= 1'b1; bus_req_byte <= 1'b0;
            bus_req_addr  <= d_base + ADDR_W'(12);
            bus_req_wdata <= (DATA_W'(d_total) << CTL_CNT_LSB) | DATA_W'(1);
          end
          if (rsp_ok) begin
            ptr <= d_link; cond_on <= 1'b0; state <= S_NEXT;
          end
        end
        S_FINISH: begin
          irq <= irq_enable; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_addr) &&
      $stable(bus_req_wdata) && $stable(bus_req_write) && $stable(bus_req_byte))); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !wait_rsp); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
  AST_IRQ_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R10
  AST_BYTE_ONLY_IN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_byte) |-> (state == S_MOVE)); // R3
  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) && bus_req_byte && !bus_req_write |-> !$past(buf_full)); // R12
endmodule

// File: tb/sim_cpdma_engine.sv
module sim_cpdma_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] STAT_ADDR = 32'h9000_0004;
  localparam logic [31:0] DATA_ADDR = 32'h9000_0000;
  localparam int POLL_IVL = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, irq_enable = 1'b0;
  logic [31:0] gather_head = '0, scatter_head = '0;
  logic busy, irq, bus_req_valid, bus_req_write, bus_req_byte;
  logic bus_req_ready = 1'b1, bus_rsp_valid = 1'b0;
  logic [31:0] bus_req_addr, bus_req_wdata, bus_rsp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .gather_head(gather_head),
    .scatter_head(scatter_head), .irq_enable(irq_enable), .busy(busy), .irq(irq),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_byte(bus_req_byte),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata));

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] wmem [logic [31:0]];
  logic [7:0]  bmem [logic [31:0]];
  logic [31:0] rq_addr [64];
  logic        rq_wr [64];
  logic        rq_byte [64];
  logic [31:0] br_addr [64];
  int rq_n, br_n, rd_seq, poll_n, gap_err, gap_chk, credit, cred_err;
  int hold_err, out_err, irq_seen, irq_busy_err, last_t;
  bit pend, outst, last_fail, hold_prev, stall_on;
  logic [31:0] pend_data, hold_addr;

  always @(posedge clk) cyc++;

  task automatic serve();
    logic [31:0] v;
    if (rq_n < 64) begin
      rq_addr[rq_n] = bus_req_addr; rq_wr[rq_n] = bus_req_write; rq_byte[rq_n] = bus_req_byte;
    end
    rq_n++;
    pend_data = '0;
    if (bus_req_write) begin
      if (bus_req_byte) bmem[bus_req_addr] = bus_req_wdata[7:0];
      else wmem[bus_req_addr] = bus_req_wdata;
    end else if (bus_req_byte) begin
      pend_data = {24'h0, 8'h30 + 8'(rd_seq)};
      rd_seq++;
      if (br_n < 64) br_addr[br_n] = bus_req_addr;
      br_n++;
      if (credit == 0) cred_err++; else credit--;
    end else if (bus_req_addr == STAT_ADDR) begin
      v = (poll_n % 3 == 2) ? 32'h80 : 32'h01;
      if (poll_n > 0 && last_fail) begin
        gap_chk++;
        if (cyc - last_t != POLL_IVL + 4) gap_err++;
      end
      last_fail = (v & 32'h80) == 0;
      if (!last_fail) credit = 2;
      last_t = cyc; poll_n++;
      pend_data = v;
    end else begin
      pend_data = wmem.exists(bus_req_addr) ? wmem[bus_req_addr] : 32'h0;
    end
  endtask

  always @(negedge clk) begin
    bus_rsp_valid = 1'b0;
    if (pend) begin
      bus_rsp_valid = 1'b1; bus_rsp_rdata = pend_data; pend = 0; outst = 0;
    end
    bus_req_ready = stall_on ? (cyc % 3 != 1) : 1'b1;
    if (rst_n && hold_prev && (!bus_req_valid || bus_req_addr != hold_addr)) hold_err++;
    hold_prev = rst_n && bus_req_valid && !bus_req_ready;
    hold_addr = bus_req_addr;
    if (rst_n && bus_req_valid && bus_req_ready) begin
      if (outst) out_err++;
      outst = 1; pend = 1;
      serve();
    end
    if (rst_n && irq) begin
      irq_seen++;
      if (busy) irq_busy_err++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; pend = 0; outst = 0; hold_prev = 0;
    wmem.delete(); bmem.delete();
    rq_n = 0; br_n = 0; rd_seq = 0; poll_n = 0; gap_err = 0; gap_chk = 0;
    credit = 1000; cred_err = 0; hold_err = 0; out_err = 0; irq_seen = 0;
    irq_busy_err = 0; last_fail = 0; last_t = 0; stall_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] link,
                          input logic [31:0] addr, input logic [31:0] ctrl,
                          input logic [31:0] w3);
    wmem[base] = link; wmem[base+4] = addr; wmem[base+8] = ctrl; wmem[base+12] = w3;
  endtask

  task automatic run(input logic [31:0] gh, input logic [31:0] sh, input logic ien,
                     input int limit, output bit finished);
    int n;
    gather_head = gh; scatter_head = sh; irq_enable = ien;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (busy && n < limit) begin @(negedge clk); n++; end
    @(negedge clk);
    finished = !busy;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 req_valid after reset", 32'(bus_req_valid), 0);
  endtask

  task automatic t_plain();
    bit fin;
    do_reset();
    stall_on = 1;
    put_desc(32'h100, 32'h0, 32'h2000, 32'h0004_0001, 32'h0);
    put_desc(32'h200, 32'h0, 32'h5000, 32'h0004_0001, 32'h0);
    run(32'h100, 32'h200, 1'b1, 3000, fin);
    chk("R10 run finished", 32'(fin), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R2 fetch address order", rq_addr[i], 32'h100 + 32'(4*i));
      chk("R2 fetch is word read", {30'h0, rq_wr[i], rq_byte[i]}, 0);
    end
    chk("R3 byte read count", 32'(br_n), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 incrementing read address", br_addr[i], 32'h2000 + 32'(i));
      chk("R4 scatter byte in order", bmem.exists(32'h5000 + 32'(i)) ? 32'(bmem[32'h5000 + 32'(i)]) : 32'hFFFF,
          32'h30 + 32'(i));
    end
    chk("R5 gather write-back", wmem[32'h10C], 32'h0004_0001);
    chk("R5 scatter write-back", wmem[32'h20C], 32'h0004_0001);
    chk("R10 one irq pulse", 32'(irq_seen), 1);
    chk("R10 irq with busy low", 32'(irq_busy_err), 0);
    chk("R11 request held while stalled", 32'(hold_err), 0);
    chk("R11 single outstanding", 32'(out_err), 0);
  endtask

  task automatic t_cond();
    bit fin;
    do_reset();
    credit = 0;
    put_desc(32'h300, 32'h340, STAT_ADDR, 32'h0002_0000 | (32'(POLL_IVL) << 4) | 32'h1, 32'h80);
    put_desc(32'h340, 32'h0, DATA_ADDR, 32'h0005_0011, 32'h0);
    put_desc(32'h200, 32'h0, 32'h5000, 32'h0005_0001, 32'h0);
    run(32'h301, 32'h200, 1'b1, 5000, fin);
    chk("R8 run finished", 32'(fin), 1);
    chk("R6 no byte before a hit", 32'(cred_err), 0);
    chk("R8 status reads for three chunks", 32'(poll_n), 9);
    chk("R8 total bytes moved", 32'(br_n), 5);
    chk("R7 poll gaps measured", 32'(gap_chk > 0), 1);
    chk("R7 poll gap equals interval plus four", 32'(gap_err), 0);
    for (int i = 0; i < 5; i++) begin
      chk("R3 held address", br_addr[i], DATA_ADDR);
      chk("R4 scatter after conditional gather", bmem.exists(32'h5000 + 32'(i)) ? 32'(bmem[32'h5000 + 32'(i)]) : 32'hFFFF,
          32'h30 + 32'(i));
    end
    chk("R5 conditional data write-back", wmem[32'h34C], 32'h0005_0001);
  endtask

  task automatic t_skip();
    bit fin; int bad;
    do_reset();
    put_desc(32'h400, 32'h440, 32'h7000, 32'h0003_0000, 32'hDEAD_BEEF);
    put_desc(32'h440, 32'h0, 32'h2000, 32'h0002_0001, 32'h0);
    put_desc(32'h200, 32'h0, 32'h5000, 32'h0002_0001, 32'h0);
    run(32'h400, 32'h200, 1'b0, 3000, fin);
    chk("R9 run finished", 32'(fin), 1);
    bad = 0;
    for (int i = 0; i < br_n && i < 64; i++) if (br_addr[i][31:12] == 20'h00007) bad++;
    chk("R9 no access to disabled target", 32'(bad), 0);
    chk("R9 bytes of enabled descriptor only", 32'(br_n), 2);
    chk("R9 disabled descriptor untouched", wmem[32'h40C], 32'hDEAD_BEEF);
    chk("R9 link followed to next", wmem[32'h44C], 32'h0002_0001);
    chk("R4 second scatter byte", bmem.exists(32'h5001) ? 32'(bmem[32'h5001]) : 32'hFFFF, 32'h31);
    chk("R10 no irq when disabled", 32'(irq_seen), 0);
  endtask

  task automatic t_full();
    do_reset();
    put_desc(32'h500, 32'h0, 32'h2000, 32'h0014_0001, 32'h0);
    put_desc(32'h200, 32'h0, 32'h5000, 32'h0014_0001, 32'h0);
    gather_head = 32'h500; scatter_head = 32'h200; irq_enable = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (400) @(negedge clk);
    chk("R12 reads stop at buffer depth", 32'(br_n), 16);
    chk("R12 engine stays busy", 32'(busy), 1);
    do_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_cond();
    t_skip();
    t_full();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule